// File: doc/BRIEF.md
# Capability Page-Control Access Checker

This block sits beside the load/store unit of a capability-aware core. The page-table walker returns two per-page controls for each access. One sets how capability loads are treated: pass, strip the tag, or trap. The other sets whether tagged capability stores are allowed. For each access the block decides whether it proceeds, proceeds with its tag removed, or takes a trap. For a load it also reports the tag value that may be written back and whether the memory read should be issued at all.

Page-level capability traps use cause codes of their own: 26 for loads and 27 for stores. They are reported like any memory exception, with the faulting virtual address as the trap value. Any other capability-extension fault uses the generic cause 28. Ordinary translation faults pass through unchanged. A misaligned capability store raises the standard store address-misaligned cause, 6.

Inputs are registered, so every result appears exactly one clock after the request is presented.

Top module: `cap_pte_checker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `trap_valid`, `tag_valid`, `tag_out`, `load_issue`, `trap_cause` and `trap_value` are all zero.
- R2: Every result follows its request by exactly one clock. When `req_valid` was low in the previous cycle, `trap_valid`, `tag_valid` and `load_issue` are low, whatever the other inputs held.
- R3: `ld_mode` = 0 (pass) is handled as follows:
  - the load does not trap;
  - `tag_valid` = 1;
  - `load_issue` = 1;
  - `tag_out` = `ld_tag` AND `ld_perm`.
- R4: `ld_mode` = 1 (strip) is handled as follows:
  - the load does not trap;
  - `tag_valid` = 1;
  - `load_issue` = 1;
  - `tag_out` = 0.
- R5: `ld_mode` = 2 or 3 (trap) with `dd_trap_en` = 0 and `ld_perm` = 1 raises cause 26 with `load_issue` = 0, so the trap comes before any memory read.
- R6: `ld_mode` 2 or 3 in the other cases is handled as follows:
  - With `dd_trap_en` = 1, the load traps with cause 26 only when `ld_tag` AND `ld_perm` is 1. That trap keeps `load_issue` = 1.
  - In every other such case the load completes with `tag_out` = 0.
- R7: A store with `st_trap` = 1 and `st_tag` = 1 raises cause 27. An untagged store, or one with `st_trap` = 0, does not trap. A store never asserts `tag_valid` or `load_issue`.
- R8: A store with `st_misaligned` = 1 raises cause 6, above every other store condition.
- R9: `xlat_fault` = 1 raises `xlat_cause` unchanged. It wins over the capability-extension fault and over both page-control checks.
- R10: `cap_fault` = 1 without a translation fault raises cause 28. It wins over the page-control checks.
- R11: Whenever `trap_valid` is 1, `trap_value` equals the `req_vaddr` of the request. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_is_store | input | 1 | 1 = capability store, 0 = capability load |
| req_vaddr | input | VA_W | Virtual address of the access |
| xlat_fault | input | 1 | Non-capability translation fault |
| xlat_cause | input | 6 | Cause code of that translation fault |
| cap_fault | input | 1 | Other capability-extension fault |
| ld_mode | input | 2 | Page load control: 0 pass, 1 strip, 2/3 trap |
| ld_tag | input | 1 | Tag of the loaded value |
| ld_perm | input | 1 | Load-capability permission of the authorising capability |
| dd_trap_en | input | 1 | Allows tag-dependent load traps |
| st_trap | input | 1 | Page forbids tagged stores |
| st_tag | input | 1 | Tag of the value being stored |
| st_misaligned | input | 1 | Store address not capability-aligned |
| trap_valid | output | 1 | Access traps |
| trap_cause | output | 6 | Trap cause code |
| trap_value | output | VA_W | Faulting virtual address |
| tag_valid | output | 1 | Load completes and `tag_out` is meaningful |
| tag_out | output | 1 | Filtered tag to write back |
| load_issue | output | 1 | Memory read for the load should be issued |

## Verification
The directed cases target the places where the trap rules meet.

- A trap-mode load with data-dependent traps enabled and an untagged value must complete with a cleared tag. A design that ignored the tag there would trap wrongly.
- With data-dependent traps disabled, the trap must suppress the read. A design that got this wrong would leave `load_issue` high.
- A misaligned tagged store to a no-store page must report 6, not 27, and a translation fault must beat a page check.
- A load that lacks permission on a trap page must neither trap nor pass a tag.

Random traffic then covers every mix of these inputs, including `req_valid` low with fault inputs set.

// File: rtl/cptc_pkg.sv
package cptc_pkg;

    typedef enum logic [1:0] {
        LDM_PASS  = 2'd0,
        LDM_STRIP = 2'd1,
        LDM_TRAP  = 2'd2,
        LDM_TRAPX = 2'd3
    } ld_mode_e;

    localparam logic [5:0] CAUSE_ST_MISALIGN = 6'd6;
    localparam logic [5:0] CAUSE_PTE_LOAD    = 6'd26;
    localparam logic [5:0] CAUSE_PTE_STORE   = 6'd27;
    localparam logic [5:0] CAUSE_CAP_GENERIC = 6'd28;

    typedef struct packed {
        logic       valid;
        logic       is_store;
        logic       xlat_fault;
        logic [5:0] xlat_cause;
        logic       cap_fault;
        ld_mode_e   ld_mode;
        logic       ld_tag;
        logic       ld_perm;
        logic       dd_en;
        logic       st_trap;
        logic       st_tag;
        logic       st_misal;
    } req_t;

    typedef struct packed {
        logic hit;
        logic early;
        logic tag;
    } ld_res_t;

    typedef struct packed {
        logic       trap;
        logic [5:0] cause;
        logic       tag_valid;
        logic       tag;
        logic       issue;
    } verdict_t;

    function automatic logic mode_traps(ld_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/cptc_load_filter.sv
module cptc_load_filter
    import cptc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ld_mode_e mode,
    input  logic     tag_in,
    input  logic     perm,
    input  logic     dd_en,
    output ld_res_t  res
);
    logic filtered;
    logic trapm;

    always_comb begin
        filtered  = tag_in & perm;
        trapm     = mode_traps(mode);
        res.early = trapm & perm & ~dd_en;
        res.hit   = trapm & perm & (~dd_en | tag_in);
        res.tag   = (mode == LDM_PASS) ? filtered : 1'b0;
    end

    AST_STRIP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode == LDM_STRIP) |-> (!res.tag && !res.hit)); // R4
    AST_NOPERM_NOTRAP: assert property (@(posedge clk) disable iff (rst)
        !perm |-> (!res.hit && !res.tag)); // R6
endmodule

// File: rtl/cptc_store_check.sv
module cptc_store_check
    import cptc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic st_trap,
    input  logic st_tag,
    output logic hit
);
    always_comb hit = st_trap & st_tag;

    AST_UNTAGGED_STORES: assert property (@(posedge clk) disable iff (rst)
        !st_tag |-> !hit); // R7
endmodule

// File: rtl/cptc_trap_select.sv
module cptc_trap_select
    import cptc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  req_t     req,
    input  ld_res_t  ld,
    input  logic     st_hit,
    output verdict_t v
);
    always_comb begin
        v = '0;
        if (req.valid) begin
            if (req.is_store) begin
                if (req.st_misal) begin
                    v.trap = 1'b1; v.cause = CAUSE_ST_MISALIGN;
                end else if (req.xlat_fault) begin
                    v.trap = 1'b1; v.cause = req.xlat_cause;
                end else if (req.cap_fault) begin
                    v.trap = 1'b1; v.cause = CAUSE_CAP_GENERIC;
                end else if (st_hit) begin
                    v.trap = 1'b1; v.cause = CAUSE_PTE_STORE;
                end
            end else begin
                if (req.xlat_fault) begin
                    v.trap = 1'b1; v.cause = req.xlat_cause;
                end else if (req.cap_fault) begin
                    v.trap = 1'b1; v.cause = CAUSE_CAP_GENERIC;
                end else begin
                    v.issue = ~ld.early;
                    if (ld.hit) begin
                        v.trap = 1'b1; v.cause = CAUSE_PTE_LOAD;
                    end else begin
                        v.tag_valid = 1'b1;
                        v.tag       = ld.tag;
                    end
                end
            end
        end
    end

    AST_MISALIGN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.is_store && req.st_misal) |-> (v.trap && v.cause == CAUSE_ST_MISALIGN)); // R8
    AST_XLAT_WINS: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.xlat_fault && !(req.is_store && req.st_misal)) |-> (v.cause == req.xlat_cause)); // R9
    AST_STORE_NO_TAG: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.is_store) |-> (!v.tag_valid && !v.issue)); // R7
    AST_EARLY_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.is_store && ld.early) |-> !v.issue); // R5
endmodule

// File: rtl/cap_pte_checker.sv
module cap_pte_checker
    import cptc_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_is_store,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            xlat_fault,
    input  logic [5:0]      xlat_cause,
    input  logic            cap_fault,
    input  logic [1:0]      ld_mode,
    input  logic            ld_tag,
    input  logic            ld_perm,
    input  logic            dd_trap_en,
    input  logic            st_trap,
    input  logic            st_tag,
    input  logic            st_misaligned,
    output logic            trap_valid,
    output logic [5:0]      trap_cause,
    output logic [VA_W-1:0] trap_value,
    output logic            tag_valid,
    output logic            tag_out,
    output logic            load_issue
);
    req_t            req_d, req_q;
    logic [VA_W-1:0] vaddr_q;
    ld_res_t         ld_res;
    logic            st_hit;
    verdict_t        verdict;

    always_comb begin
        req_d.valid      = req_valid;
        req_d.is_store   = req_is_store;
        req_d.xlat_fault = xlat_fault;
        req_d.xlat_cause = xlat_cause;
        req_d.cap_fault  = cap_fault;
        req_d.ld_mode    = ld_mode_e'(ld_mode);
        req_d.ld_tag     = ld_tag;
        req_d.ld_perm    = ld_perm;
        req_d.dd_en      = dd_trap_en;
        req_d.st_trap    = st_trap;
        req_d.st_tag     = st_tag;
        req_d.st_misal   = st_misaligned;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            vaddr_q <= '0;
        end else begin
            req_q   <= req_d;
            vaddr_q <= req_vaddr;
        end
    end

    cptc_load_filter u_load (
        .clk    (clk),
        .rst    (rst),
        .mode   (req_q.ld_mode),
        .tag_in (req_q.ld_tag),
        .perm   (req_q.ld_perm),
        .dd_en  (req_q.dd_en),
        .res    (ld_res)
    );

    cptc_store_check u_store (
        .clk     (clk),
        .rst     (rst),
        .st_trap (req_q.st_trap),
        .st_tag  (req_q.st_tag),
        .hit     (st_hit)
    );

    cptc_trap_select u_sel (
        .clk    (clk),
        .rst    (rst),
        .req    (req_q),
        .ld     (ld_res),
        .st_hit (st_hit),
        .v      (verdict)
    );

    always_comb begin
        trap_valid = verdict.trap;
        trap_cause = verdict.cause;
        trap_value = verdict.trap ? vaddr_q : '0;
        tag_valid  = verdict.tag_valid;
        tag_out    = verdict.tag;
        load_issue = verdict.issue;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!trap_valid && !tag_valid && !load_issue)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid) |-> (!trap_valid && !tag_valid && !load_issue)); // R2
    AST_TVAL_ADDR: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (trap_value == $past(req_vaddr))); // R11
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(trap_valid && tag_valid)); // R2
    AST_PASS_TAG: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid && !req_is_store && !xlat_fault && !cap_fault) && $past(ld_mode) == 2'd0)
        |-> (tag_valid && tag_out == $past(ld_tag && ld_perm))); // R3
endmodule

// File: tb/tb_cap_pte_checker.sv
module tb_cap_pte_checker;
    localparam int VA_W = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 0, req_is_store = 0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            xlat_fault = 0;
    logic [5:0]      xlat_cause = '0;
    logic            cap_fault = 0;
    logic [1:0]      ld_mode = '0;
    logic            ld_tag = 0, ld_perm = 0, dd_trap_en = 0;
    logic            st_trap = 0, st_tag = 0, st_misaligned = 0;
    logic            trap_valid, tag_valid, tag_out, load_issue;
    logic [5:0]      trap_cause;
    logic [VA_W-1:0] trap_value;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cap_pte_checker #(.VA_W(VA_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_vaddr(req_vaddr), .xlat_fault(xlat_fault), .xlat_cause(xlat_cause),
        .cap_fault(cap_fault), .ld_mode(ld_mode), .ld_tag(ld_tag), .ld_perm(ld_perm),
        .dd_trap_en(dd_trap_en), .st_trap(st_trap), .st_tag(st_tag),
        .st_misaligned(st_misaligned), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_value(trap_value), .tag_valid(tag_valid), .tag_out(tag_out),
        .load_issue(load_issue)
    );

    // packed outcome: trap, cause, value, tag_valid, tag, issue
    function automatic logic [VA_W+9:0] expect_out();
        logic tr, tv, tg, is;
        logic [5:0] c;
        tr = 0; tv = 0; tg = 0; is = 0; c = '0;
        if (req_valid) begin
            if (req_is_store) begin
                if (st_misaligned)          begin tr = 1; c = 6'd6;  end
                else if (xlat_fault)        begin tr = 1; c = xlat_cause; end
                else if (cap_fault)         begin tr = 1; c = 6'd28; end
                else if (st_trap && st_tag) begin tr = 1; c = 6'd27; end
            end else begin
                if (xlat_fault)      begin tr = 1; c = xlat_cause; end
                else if (cap_fault)  begin tr = 1; c = 6'd28; end
                else begin
                    is = !(ld_mode[1] && ld_perm && !dd_trap_en);
                    if (ld_mode[1] && ld_perm && (!dd_trap_en || ld_tag)) begin
                        tr = 1; c = 6'd26;
                    end else begin
                        tv = 1;
                        tg = (ld_mode == 2'd0) ? (ld_tag & ld_perm) : 1'b0;
                    end
                end
            end
        end
        return {tr, c, (tr ? req_vaddr : {VA_W{1'b0}}), tv, tg, is};
    endfunction

    function automatic string req_name();
        if (!req_valid) return "R2";
        if (req_is_store) begin
            if (st_misaligned) return "R8";
            if (xlat_fault) return "R9";
            if (cap_fault) return "R10";
            return "R7";
        end
        if (xlat_fault) return "R9";
        if (cap_fault) return "R10";
        if (ld_mode == 2'd0) return "R3";
        if (ld_mode == 2'd1) return "R4";
        if (ld_perm && !dd_trap_en) return "R5";
        return "R6";
    endfunction

    task automatic compare(input string rq, input logic [VA_W+9:0] exp);
        logic [VA_W+9:0] act;
        act = {trap_valid, trap_cause, trap_value, tag_valid, tag_out, load_issue};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h (R11 trap_value included)", rq, act, exp);
        end
    endtask

    task automatic step();
        logic [VA_W+9:0] exp;
        string rq;
        exp = expect_out();
        rq  = req_name();
        @(negedge clk);
        compare(rq, exp);
    endtask

    task automatic set_load(input logic [1:0] m, input logic t, input logic p, input logic dd);
        req_valid = 1; req_is_store = 0; xlat_fault = 0; cap_fault = 0;
        ld_mode = m; ld_tag = t; ld_perm = p; dd_trap_en = dd;
        req_vaddr = {$urandom, $urandom};
    endtask

    task automatic set_store(input logic tr, input logic tg, input logic mis);
        req_valid = 1; req_is_store = 1; xlat_fault = 0; cap_fault = 0;
        st_trap = tr; st_tag = tg; st_misaligned = mis;
        req_vaddr = {$urandom, $urandom};
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_c0de);
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        compare("R1", '0);
        rst = 0;
        req_valid = 0;
        @(negedge clk);
        compare("R1", '0);
        // R2: idle cycle with faults present
        req_valid = 0; xlat_fault = 1; xlat_cause = 6'd13; st_misaligned = 1; step();
        xlat_fault = 0; st_misaligned = 0;
        // R3 pass mode
        set_load(2'd0, 1, 1, 0); step();
        set_load(2'd0, 1, 0, 1); step();
        // R4 strip
        set_load(2'd1, 1, 1, 0); step();
        // R5 early trap, both trap encodings
        set_load(2'd2, 0, 1, 0); step();
        set_load(2'd3, 1, 1, 0); step();
        // R6 tag-dependent
        set_load(2'd2, 1, 1, 1); step();
        set_load(2'd2, 0, 1, 1); step();
        set_load(2'd2, 1, 0, 0); step();
        // R7 store page control
        set_store(1, 1, 0); step();
        set_store(1, 0, 0); step();
        set_store(0, 1, 0); step();
        // R8 misaligned beats page trap and translation fault
        set_store(1, 1, 1); xlat_fault = 1; xlat_cause = 6'd15; step();
        // R9 translation fault beats capability checks
        set_store(1, 1, 0); xlat_fault = 1; xlat_cause = 6'd15; cap_fault = 1; step();
        set_load(2'd2, 1, 1, 0); xlat_fault = 1; xlat_cause = 6'd13; step();
        // R10 generic capability fault beats page control
        set_load(2'd2, 1, 1, 0); cap_fault = 1; step();
        set_store(1, 1, 0); cap_fault = 1; step();
        // random mix
        for (int i = 0; i < 3000; i++) begin
            req_valid     = ($urandom % 8) != 0;
            req_is_store  = $urandom % 2;
            req_vaddr     = {$urandom, $urandom};
            xlat_fault    = ($urandom % 6) == 0;
            xlat_cause    = ($urandom % 2) ? 6'd13 : 6'd15;
            cap_fault     = ($urandom % 7) == 0;
            ld_mode       = 2'($urandom);
            ld_tag        = $urandom % 2;
            ld_perm       = $urandom % 2;
            dd_trap_en    = $urandom % 2;
            st_trap       = $urandom % 2;
            st_tag        = $urandom % 2;
            st_misaligned = ($urandom % 5) == 0;
            step();
        end
        req_valid = 0;
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule